// File: doc/BRIEF.md
# Buffered Addressable Parallel Slave Port

This block lets an external host exchange bytes with on-chip logic over an asynchronous 8-bit parallel bus. The bus has active-low chip select, read strobe and write strobe lines, plus a 2-bit address. Inside the block are four read buffers and four write buffers. Local logic loads the read buffers and sees the write buffers at all times. The host reads the read buffers and fills the write buffers.

Three configuration inputs choose the behaviour:
- **Legacy mode.** The host always reaches buffer 0 and the address lines are ignored.
- **Legacy mode with auto-increment.** A read pointer and a write pointer each step through buffers 0 to 3 and then wrap back to 0.
- **Addressable mode.** The 2-bit address names the buffer directly.

An interrupt pulse tells local logic that the host has finished an access. Depending on the configuration, the pulse comes after every access, only after an access to the last buffer, or never.

All strobes are brought into the clock domain through a two-stage synchroniser. A host access ends when its strobe is released. The block acts on that release. It captures write data, advances pointers and raises the interrupt on the third rising clock edge after the strobe rises.

Top module: `psp_slave_port`

## Requirements
- R1: While reset is low, and after it is released, every write buffer reads 0, every read buffer holds 0, both pointers are 0 and `irq_pulse` is 0.
- R2: `host_doe` is 1 exactly while `host_cs_n` and `host_rd_n` are both 0. `host_dout` shows the selected read buffer while `host_doe` is 1, and 0 otherwise.
- R3: A write takes place when `host_wr_n` rises while `host_cs_n` is 0. The byte on `host_din` enters the selected write buffer on the third rising clock edge after that release.
- R4: In legacy mode (`cfg_addr_mode`=0) with `cfg_autoinc`=0, every read and write uses buffer 0 and `host_addr` is ignored.
- R5: In addressable mode (`cfg_addr_mode`=1), `host_addr` selects the buffer for both reads and writes.
- R6: In legacy mode with `cfg_autoinc`=1, the read pointer and the write pointer each advance by one after an access of their own kind. They move independently of each other, and each wraps from 3 to 0.
- R7: In addressable mode, `cfg_autoinc` has no effect and neither pointer moves.
- R8: With `cfg_irq_sel`=01, every completed read or write raises `irq_pulse`.
- R9: With `cfg_irq_sel`=11 in legacy auto-increment mode, `irq_pulse` is raised only when read buffer 3 is read or write buffer 3 is written.
- R10: With `cfg_irq_sel`=11 in addressable mode, `irq_pulse` is raised only on an access with `host_addr`=3.
- R11: With `cfg_irq_sel`=00 or 10, `irq_pulse` stays 0.
- R12: `irq_pulse` is high for exactly one clock cycle per interrupt. It rises on the same edge that completes the access.
- R13: Strobe activity while `host_cs_n` is 1 changes no buffer or pointer and raises no interrupt.
- R14: When `loc_we`=1 at a rising edge, `loc_data` is stored in read buffer `loc_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr_mode | input | 1 | 1 selects addressable mode, 0 selects legacy mode |
| cfg_autoinc | input | 1 | Enables pointer auto-increment in legacy mode |
| cfg_irq_sel | input | 2 | Interrupt option: 00 none, 01 every access, 10 none, 11 last buffer |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_addr | input | 2 | Host buffer address, used in addressable mode |
| host_din | input | 8 | Data driven by the host during writes |
| host_dout | output | 8 | Data returned to the host during reads |
| host_doe | output | 1 | Output enable for the host data pads |
| loc_we | input | 1 | Local write enable for the read buffers |
| loc_idx | input | 2 | Read buffer index for local loads |
| loc_data | input | 8 | Byte loaded by local logic |
| loc_wbufs | output | 32 | All write buffers; buffer n is in bits 8n+7 down to 8n |
| irq_pulse | output | 1 | One-clock interrupt pulse |

## Verification
The bench runs the same family of host reads and writes under each configuration and checks all outputs at every clock.

- **Fixed legacy mode.** The address is set to nonzero values. Any reliance on it shows up as a write landing in the wrong buffer.
- **Auto-increment mode.** Runs of five writes and five reads, interleaved with each other, separate correct wrapping from a shared or stuck pointer. The interrupt must fall on the fourth access only.
- **Addressable mode.** Accesses at addresses 3 and 1 separate an address-based interrupt from a pointer-based one. A return to auto-increment mode then shows whether the pointers moved when they should have stayed put.
- **Ignored accesses.** Strobes with chip select inactive, and the two silent interrupt options, must leave buffers and the interrupt line untouched.

// File: rtl/psp_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the parallel slave port.
package psp_pkg;
    // Interrupt option codes as seen on cfg_irq_sel.
    typedef enum logic [1:0] {
        IRQ_OFF   = 2'b00,
        IRQ_EACH  = 2'b01,
        IRQ_STALL = 2'b10,
        IRQ_LAST  = 2'b11
    } irq_sel_e;
endpackage

// File: rtl/psp_sync.sv
`timescale 1ns/1ps
// psp_sync: multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes each bit is a level that stays stable for several clocks.
module psp_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // One flip-flop stage of the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= (g == 0) ? d : stg[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/psp_strobe_det.sv
`timescale 1ns/1ps
// psp_strobe_det: turns synchronised strobes into one-clock "access done"
// pulses, fired when a strobe is released while chip select is active.
// Assumes inputs already synchronised to clk.
module psp_strobe_det (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_s,
    input  logic rd_n_s,
    input  logic wr_n_s,
    output logic rd_done,
    output logic wr_done
);
    logic rd_act, wr_act, rd_act_q, wr_act_q;

    assign rd_act = !rd_n_s && !cs_n_s;
    assign wr_act = !wr_n_s && !cs_n_s;

    // Remember last cycle's activity to find its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_act_q <= 1'b0;
            wr_act_q <= 1'b0;
        end else begin
            rd_act_q <= rd_act;
            wr_act_q <= wr_act;
        end
    end

    assign rd_done = rd_act_q && !rd_act;
    assign wr_done = wr_act_q && !wr_act;
endmodule

// File: rtl/psp_index_ctl.sv
`timescale 1ns/1ps
// psp_index_ctl: chooses the buffer index for host reads and writes, keeps
// the auto-increment pointers and produces the interrupt pulse.
// Assumes rd_done/wr_done are single-cycle pulses.
module psp_index_ctl
    import psp_pkg::*;
#(
    parameter int NBUF = 4,
    localparam int IW  = $clog2(NBUF)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_addr_mode,
    input  logic          cfg_autoinc,
    input  logic [1:0]    cfg_irq_sel,
    input  logic [IW-1:0] host_addr,
    input  logic          rd_done,
    input  logic          wr_done,
    output logic [IW-1:0] rd_idx,
    output logic [IW-1:0] wr_idx,
    output logic [IW-1:0] rd_ptr,
    output logic [IW-1:0] wr_ptr,
    output logic          irq_pulse
);
    localparam logic [IW-1:0] LAST = IW'(NBUF-1);

    irq_sel_e irq_sel;
    logic     step_en, irq_evt;

    assign irq_sel = irq_sel_e'(cfg_irq_sel);
    assign step_en = !cfg_addr_mode && cfg_autoinc;

    // Pick the buffer index from address, pointer or fixed zero.
    always_comb begin
        if (cfg_addr_mode) begin
            rd_idx = host_addr;
            wr_idx = host_addr;
        end else if (cfg_autoinc) begin
            rd_idx = rd_ptr;
            wr_idx = wr_ptr;
        end else begin
            rd_idx = '0;
            wr_idx = '0;
        end
    end

    // Advance each pointer after its own access, wrapping at the last buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
        end else begin
            if (step_en && rd_done) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (step_en && wr_done) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
        end
    end

    // Decide whether the finishing access deserves an interrupt.
    always_comb begin
        case (irq_sel)
            IRQ_EACH: irq_evt = rd_done || wr_done;
            IRQ_LAST: irq_evt = (rd_done && rd_idx == LAST) || (wr_done && wr_idx == LAST);
            default:  irq_evt = 1'b0;
        endcase
    end

    // Register the interrupt as a one-clock pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_pulse <= 1'b0;
        else        irq_pulse <= irq_evt;
    end
endmodule

// File: rtl/psp_buf_store.sv
`timescale 1ns/1ps
// psp_buf_store: holds the read buffers (loaded locally, read by the host)
// and the write buffers (written by the host, seen locally).
// Assumes host_we is a single-cycle pulse.
module psp_buf_store #(
    parameter int DW   = 8,
    parameter int NBUF = 4,
    localparam int IW  = $clog2(NBUF)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic [IW-1:0]      host_widx,
    input  logic [DW-1:0]      host_wdata,
    input  logic [IW-1:0]      host_ridx,
    output logic [DW-1:0]      host_rdata,
    input  logic               loc_we,
    input  logic [IW-1:0]      loc_idx,
    input  logic [DW-1:0]      loc_data,
    output logic [NBUF*DW-1:0] loc_wbufs
);
    logic [DW-1:0] rbuf [NBUF];
    logic [DW-1:0] wbuf [NBUF];

    genvar g;
    generate
        for (g = 0; g < NBUF; g++) begin : g_buf
            // Read buffer g: loaded by local logic.
            always_ff @(posedge clk) begin
                if (!rst_n)                                   rbuf[g] <= '0;
                else if (loc_we && loc_idx == IW'(g))         rbuf[g] <= loc_data;
            end
            // Write buffer g: loaded by a finished host write.
            always_ff @(posedge clk) begin
                if (!rst_n)                                   wbuf[g] <= '0;
                else if (host_we && host_widx == IW'(g))      wbuf[g] <= host_wdata;
            end
            assign loc_wbufs[g*DW +: DW] = wbuf[g];
        end
    endgenerate

    assign host_rdata = rbuf[host_ridx];
endmodule

// File: rtl/psp_slave_port.sv
`timescale 1ns/1ps
// psp_slave_port: top of the parallel slave port. Synchronises host strobes,
// detects completed accesses, routes them to buffers and raises interrupts.
// Assumes the host holds cs, address and write data stable for at least
// three clocks after releasing a strobe.
module psp_slave_port #(
    parameter int DW          = 8,
    parameter int NBUF        = 4,
    parameter int SYNC_STAGES = 2,
    localparam int IW         = $clog2(NBUF)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_addr_mode,
    input  logic               cfg_autoinc,
    input  logic [1:0]         cfg_irq_sel,
    input  logic               host_cs_n,
    input  logic               host_rd_n,
    input  logic               host_wr_n,
    input  logic [IW-1:0]      host_addr,
    input  logic [DW-1:0]      host_din,
    output logic [DW-1:0]      host_dout,
    output logic               host_doe,
    input  logic               loc_we,
    input  logic [IW-1:0]      loc_idx,
    input  logic [DW-1:0]      loc_data,
    output logic [NBUF*DW-1:0] loc_wbufs,
    output logic               irq_pulse
);
    logic          cs_n_s, rd_n_s, wr_n_s;
    logic          rd_done, wr_done;
    logic [IW-1:0] rd_idx, wr_idx, rd_ptr, wr_ptr;
    logic [DW-1:0] rd_data;

    psp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({host_cs_n, host_rd_n, host_wr_n}),
        .q     ({cs_n_s, rd_n_s, wr_n_s})
    );

    psp_strobe_det u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_s  (cs_n_s),
        .rd_n_s  (rd_n_s),
        .wr_n_s  (wr_n_s),
        .rd_done (rd_done),
        .wr_done (wr_done)
    );

    psp_index_ctl #(.NBUF(NBUF)) u_idx (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_addr_mode (cfg_addr_mode),
        .cfg_autoinc   (cfg_autoinc),
        .cfg_irq_sel   (cfg_irq_sel),
        .host_addr     (host_addr),
        .rd_done       (rd_done),
        .wr_done       (wr_done),
        .rd_idx        (rd_idx),
        .wr_idx        (wr_idx),
        .rd_ptr        (rd_ptr),
        .wr_ptr        (wr_ptr),
        .irq_pulse     (irq_pulse)
    );

    psp_buf_store #(.DW(DW), .NBUF(NBUF)) u_bufs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (wr_done),
        .host_widx  (wr_idx),
        .host_wdata (host_din),
        .host_ridx  (rd_idx),
        .host_rdata (rd_data),
        .loc_we     (loc_we),
        .loc_idx    (loc_idx),
        .loc_data   (loc_data),
        .loc_wbufs  (loc_wbufs)
    );

    // Drive the host bus only during an active, selected read.
    assign host_doe  = !host_cs_n && !host_rd_n;
    assign host_dout = host_doe ? rd_data : '0;
endmodule

// File: rtl/psp_slave_port_chk.sv
`timescale 1ns/1ps
// psp_slave_port_chk: temporal checks on the slave port, bound to the top.
module psp_slave_port_chk #(
    parameter int DW   = 8,
    parameter int NBUF = 4,
    localparam int IW  = $clog2(NBUF)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_addr_mode,
    input logic               cfg_autoinc,
    input logic [1:0]         cfg_irq_sel,
    input logic               host_cs_n,
    input logic               host_rd_n,
    input logic               host_doe,
    input logic [DW-1:0]      host_dout,
    input logic [NBUF*DW-1:0] loc_wbufs,
    input logic               irq_pulse,
    input logic               rd_done,
    input logic               wr_done,
    input logic [IW-1:0]      rd_ptr
);
    localparam logic [IW-1:0] LAST = IW'(NBUF-1);

    // R2: output enable only with an active selected read
    a_r2_doe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        host_doe |-> (!host_cs_n && !host_rd_n));

    // R2: bus idles at zero when not driven
    a_r2_dout_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !host_doe |-> (host_dout == '0));

    // R3: write buffers change only after a detected write completion
    a_r3_write_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(loc_wbufs) |-> $past(wr_done));

    // R11: interrupt only under options 01 or 11
    a_r11_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(cfg_irq_sel[0]));

    // R8: an interrupt always follows a completed access
    a_r8_irq_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(rd_done || wr_done));

    // R6: read pointer steps by one with wrap after a legacy auto-increment read
    a_r6_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_done) && $past(!cfg_addr_mode && cfg_autoinc))
        |-> (rd_ptr == (($past(rd_ptr) == LAST) ? '0 : $past(rd_ptr) + 1'b1)));

    // R7: pointer holds still outside legacy auto-increment reads
    a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_ptr) |-> $past(rd_done && !cfg_addr_mode && cfg_autoinc));
endmodule

bind psp_slave_port psp_slave_port_chk #(.DW(DW), .NBUF(NBUF)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_addr_mode (cfg_addr_mode),
    .cfg_autoinc   (cfg_autoinc),
    .cfg_irq_sel   (cfg_irq_sel),
    .host_cs_n     (host_cs_n),
    .host_rd_n     (host_rd_n),
    .host_doe      (host_doe),
    .host_dout     (host_dout),
    .loc_wbufs     (loc_wbufs),
    .irq_pulse     (irq_pulse),
    .rd_done       (rd_done),
    .wr_done       (wr_done),
    .rd_ptr        (rd_ptr)
);

// File: tb/psp_slave_port_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural model of the port, compared with the outputs each clock.
module psp_slave_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_addr_mode = 1'b0, cfg_autoinc = 1'b0;
    logic [1:0]  cfg_irq_sel = 2'b00;
    logic        host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1;
    logic [1:0]  host_addr = 2'd0;
    logic [7:0]  host_din = 8'h00;
    logic [7:0]  host_dout;
    logic        host_doe;
    logic        loc_we = 1'b0;
    logic [1:0]  loc_idx = 2'd0;
    logic [7:0]  loc_data = 8'h00;
    logic [31:0] loc_wbufs;
    logic        irq_pulse;

    always #5 clk = ~clk;

    psp_slave_port dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_addr_mode(cfg_addr_mode), .cfg_autoinc(cfg_autoinc), .cfg_irq_sel(cfg_irq_sel),
        .host_cs_n(host_cs_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
        .host_addr(host_addr), .host_din(host_din), .host_dout(host_dout), .host_doe(host_doe),
        .loc_we(loc_we), .loc_idx(loc_idx), .loc_data(loc_data),
        .loc_wbufs(loc_wbufs), .irq_pulse(irq_pulse)
    );

    // Reference model state
    int    m_rbuf [4];
    int    m_wbuf [4];
    int    m_rptr = 0, m_wptr = 0;
    bit    m_irq = 0;
    int    checks = 0, errors = 0;
    string cur_req = "R1";

    function automatic int pick_idx(bit is_read);
        if (cfg_addr_mode) return int'(host_addr);
        if (cfg_autoinc)   return is_read ? m_rptr : m_wptr;
        return 0;
    endfunction

    function automatic bit irq_for(int idx);
        if (cfg_irq_sel == 2'b01) return 1'b1;
        if (cfg_irq_sel == 2'b11) return idx == 3;
        return 1'b0;
    endfunction

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Advance one clock and compare every output with the model.
    task automatic step();
        logic [31:0] ew;
        bit          edoe;
        int          edout;
        @(negedge clk);
        for (int i = 0; i < 4; i++) ew[i*8 +: 8] = 8'(m_wbuf[i]);
        edoe  = !host_rd_n && !host_cs_n;
        edout = edoe ? m_rbuf[pick_idx(1'b1)] : 0;
        check(cur_req, int'(irq_pulse), int'(m_irq), "irq_pulse");
        check(cur_req, int'(loc_wbufs), int'(ew), "loc_wbufs");
        check(cur_req, int'(host_doe), int'(edoe), "host_doe");
        check(cur_req, int'(host_dout), edout, "host_dout");
    endtask

    // Host access; is_read selects read or write, use_cs selects chip select.
    task automatic host_access(bit is_read, int addr, int data, bit use_cs);
        int    idx;
        string saved;
        host_cs_n = !use_cs;
        host_addr = 2'(addr);
        host_din  = 8'(data);
        if (is_read) host_rd_n = 1'b0; else host_wr_n = 1'b0;
        step(); step(); step();
        host_rd_n = 1'b1;
        host_wr_n = 1'b1;
        step(); step();
        if (use_cs) begin
            idx = pick_idx(is_read);
            if (!is_read) m_wbuf[idx] = data;
            m_irq = irq_for(idx);
            if (!cfg_addr_mode && cfg_autoinc) begin
                if (is_read) m_rptr = (m_rptr + 1) % 4;
                else         m_wptr = (m_wptr + 1) % 4;
            end
        end
        step();
        m_irq = 1'b0;
        saved = cur_req;
        cur_req = "R12";
        step();
        cur_req = saved;
        host_cs_n = 1'b1;
        step();
    endtask

    task automatic local_load(int idx, int data);
        loc_we = 1'b1; loc_idx = 2'(idx); loc_data = 8'(data);
        m_rbuf[idx] = data;
        step();
        loc_we = 1'b0;
    endtask

    task automatic set_cfg(bit am, bit ai, logic [1:0] irq);
        cfg_addr_mode = am; cfg_autoinc = ai; cfg_irq_sel = irq;
        step();
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin m_rbuf[i] = 0; m_wbuf[i] = 0; end
        // R1: outputs during and after reset
        cur_req = "R1";
        step(); step(); step();
        rst_n = 1'b1;
        step();
        // R14: load all read buffers locally
        cur_req = "R14";
        local_load(0, 8'hA0); local_load(1, 8'hB1);
        local_load(2, 8'hC2); local_load(3, 8'hD3);
        // R3 / R8: plain legacy write, interrupt on every access
        set_cfg(1'b0, 1'b0, 2'b01);
        cur_req = "R3";
        host_access(1'b0, 0, 8'h11, 1'b1);
        // R4: address ignored in fixed legacy mode
        cur_req = "R4";
        host_access(1'b0, 2, 8'h22, 1'b1);
        host_access(1'b1, 3, 0, 1'b1);
        // R13: strobes without chip select
        cur_req = "R13";
        host_access(1'b0, 0, 8'h99, 1'b0);
        host_access(1'b1, 0, 0, 1'b0);
        // R2: read strobe alone does not drive the bus
        cur_req = "R2";
        host_rd_n = 1'b0; step(); step(); host_rd_n = 1'b1; step(); step(); step();
        // R6 / R9: auto-increment with last-buffer interrupt, wrapping pointers
        set_cfg(1'b0, 1'b1, 2'b11);
        cur_req = "R9";
        for (int k = 0; k < 5; k++) host_access(1'b0, 0, 8'h30 + k, 1'b1);
        cur_req = "R6";
        for (int k = 0; k < 5; k++) host_access(1'b1, 0, 0, 1'b1);
        host_access(1'b0, 0, 8'h55, 1'b1);
        host_access(1'b1, 0, 0, 1'b1);
        // R5 / R10 / R7: addressable mode
        set_cfg(1'b1, 1'b1, 2'b11);
        cur_req = "R10";
        host_access(1'b0, 3, 8'h66, 1'b1);
        host_access(1'b0, 1, 8'h77, 1'b1);
        cur_req = "R5";
        host_access(1'b1, 2, 0, 1'b1);
        host_access(1'b1, 3, 0, 1'b1);
        cur_req = "R7";
        set_cfg(1'b0, 1'b1, 2'b11);
        host_access(1'b1, 0, 0, 1'b1);
        host_access(1'b0, 0, 8'h88, 1'b1);
        // R11: silent interrupt options
        cur_req = "R11";
        set_cfg(1'b1, 1'b0, 2'b00);
        host_access(1'b0, 3, 8'h44, 1'b1);
        set_cfg(1'b1, 1'b0, 2'b10);
        host_access(1'b0, 3, 8'h45, 1'b1);
        host_access(1'b1, 3, 0, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule